// File: doc/BRIEF.md
# Configurable-Lane Pixel Serializer

This block accepts one parallel video pixel at a time and sends it out over one, two or three serial lanes that run at bit rate. A pixel holds 24 colour bits (red, green, blue, eight bits each), active-low horizontal and vertical sync, an active-high data-enable and two auxiliary bits. The block adds an odd parity bit and packs all of it into a fixed 30-bit word. That word is then spread over the selected number of lanes. One lane sends 30 bit slots per word, two lanes send 15 and three lanes send 10.

The whole block runs on the bit clock. The pixel input is a valid/ready stream, and each accepted transfer marks a word boundary. `pix_ready` is high when the block is idle, and also during the last bit slot of the word in flight. A transfer happens on a rising edge where `pix_valid` and `pix_ready` are both high. The source may hold `pix_valid` high with the same or different data for as long as it likes. A word accepted in the last slot of its predecessor follows it with no gap. The serial side cannot be stalled. `ser_valid` marks slots that carry data, and `ser_first` marks the first slot of each word. The lane-count select is a plain control input and is read only when a word is accepted.

Top module: `pix_lane_serializer`

## Requirements
- R1: The word is laid out as bits 7:0 red, 15:8 green, 23:16 blue, 24 hsync_n, 25 vsync_n, 26 data-enable, 28:27 auxiliary, 29 parity. It is captured at acceptance, and later input changes do not alter the word being sent.
- R2: Bit 29 is chosen so that bits 0 to 26 plus bit 29 together hold an odd number of ones. The auxiliary bits 28:27 play no part in parity.
- R3: `lane_sel` value 2 selects two lanes with 15 slots per word, and value 3 selects three lanes with 10 slots. Values 0 and 1 select one lane with 30 slots.
- R4: With N lanes, word bit k appears on `ser_data[k mod N]` in slot k div N. Slot 0 is the cycle after acceptance, and slots follow on consecutive cycles.
- R5: `pix_ready` is high when idle or in the last slot of the current word, and low otherwise. A word accepted in the last slot begins its slot 0 on the very next cycle.
- R6: `ser_first` is high exactly in slot 0 of each word.
- R7: `ser_valid` is high exactly in cycles that carry a word slot. When idle, `ser_valid` and all lanes are low.
- R8: Lanes with index at or above the selected lane count stay low.
- R9: A change of `lane_sel` while a word is in flight has no effect on that word. It applies from the next accepted word.
- R10: After reset `pix_ready` is high and `ser_valid`, `ser_first` and all lanes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_sel | input | 2 | Lane-count select (0/1: one, 2: two, 3: three) |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Block can take a word this cycle |
| pix_red | input | 8 | Red component |
| pix_green | input | 8 | Green component |
| pix_blue | input | 8 | Blue component |
| pix_hsync_n | input | 1 | Horizontal sync, active low |
| pix_vsync_n | input | 1 | Vertical sync, active low |
| pix_de | input | 1 | Data enable, active high |
| pix_aux | input | 2 | Auxiliary side-band bits |
| ser_data | output | 3 | Serial lane outputs, one bit per lane per slot |
| ser_valid | output | 1 | Current slot carries word data |
| ser_first | output | 1 | First slot of a word |

## Verification
The bench changes `lane_sel` on every cycle while words are in flight. A design that latched the select each cycle instead of at acceptance would scramble the bit-to-lane mapping or cut a word short. It also runs back-to-back transfers in every lane mode. A ready that rose one slot late would leave an idle gap, and one that rose early would drop the final slot. Each word is rebuilt from the lanes and checked for odd parity with the auxiliary bits left out, and for field order. A design that folded the auxiliary bits into parity, or swapped fields, fails that check on random data. Lanes above the selected count are watched on every cycle, to catch stale bits leaking onto an unused lane.

// File: rtl/pxser_pkg.sv
package pxser_pkg;
  localparam int MAX_LANES = 3;

  typedef logic [1:0] lane_cnt_t;

  function automatic lane_cnt_t decode_lanes(input logic [1:0] sel);
    case (sel)
      2'd2:    return 2'd2;
      2'd3:    return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/pxser_word_pack.sv
module pxser_word_pack #(
  parameter int COLOR_W = 8,
  parameter int AUX_W   = 2,
  localparam int DATA_W = 3 * COLOR_W + 3,
  localparam int WORD_W = DATA_W + AUX_W + 1
) (
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hsync_n,
  input  logic               vsync_n,
  input  logic               de,
  input  logic [AUX_W-1:0]   aux,
  output logic [WORD_W-1:0]  word
);
  logic [DATA_W-1:0] covered;
  logic              odd_bit;

  always_comb begin
    covered = {de, vsync_n, hsync_n, blue, green, red};
    odd_bit = ~(^covered);
    word    = {odd_bit, aux, covered};
  end
endmodule

// File: rtl/pxser_lane_decode.sv
module pxser_lane_decode
  import pxser_pkg::*;
#(
  parameter int WORD_W = 30,
  localparam int SW    = $clog2(WORD_W)
) (
  input  logic [1:0]    lane_sel,
  output lane_cnt_t     lane_cnt,
  output logic [SW-1:0] last_slot
);
  localparam int LAST1 = WORD_W - 1;
  localparam int LAST2 = (WORD_W + 1) / 2 - 1;
  localparam int LAST3 = (WORD_W + 2) / 3 - 1;

  always_comb begin
    lane_cnt = decode_lanes(lane_sel);
    case (lane_cnt)
      2'd2:    last_slot = SW'(LAST2);
      2'd3:    last_slot = SW'(LAST3);
      default: last_slot = SW'(LAST1);
    endcase
  end
endmodule

// File: rtl/pxser_slot_ctrl.sv
module pxser_slot_ctrl
  import pxser_pkg::*;
#(
  parameter int WORD_W = 30,
  localparam int SW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] word_in,
  input  lane_cnt_t         cnt_in,
  input  logic [SW-1:0]     last_in,
  output logic              busy,
  output logic [SW-1:0]     slot,
  output lane_cnt_t         cnt_q,
  output logic [WORD_W-1:0] word_q
);
  logic [SW-1:0] last_q;
  logic          at_last;
  logic          take;

  always_comb begin
    at_last  = (slot == last_q);
    in_ready = !busy || at_last;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      last_q <= '0;
      cnt_q  <= 2'd1;
      word_q <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      slot   <= '0;
      last_q <= last_in;
      cnt_q  <= cnt_in;
      word_q <= word_in;
    end else if (busy) begin
      if (at_last) begin
        busy <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> $stable(word_q)); // R1
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> $stable(cnt_q)); // R9
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_ready) |=> (busy && slot == $past(slot) + 1'b1)); // R4
endmodule

// File: rtl/pxser_lane_mux.sv
module pxser_lane_mux
  import pxser_pkg::*;
#(
  parameter int WORD_W = 30,
  localparam int SW    = $clog2(WORD_W),
  localparam int IW    = $clog2(WORD_W * MAX_LANES + MAX_LANES)
) (
  input  logic                 busy,
  input  logic [SW-1:0]        slot,
  input  lane_cnt_t            cnt,
  input  logic [WORD_W-1:0]    word,
  output logic [MAX_LANES-1:0] lanes
);
  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] shifted;
    logic              lane_bit;

    always_comb begin
      idx      = IW'(slot) * IW'(cnt) + IW'(i);
      shifted  = word >> idx;
      lane_bit = busy && (IW'(i) < IW'(cnt)) && (idx < IW'(WORD_W)) && shifted[0];
    end

    assign lanes[i] = lane_bit;
  end
endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
  import pxser_pkg::*;
#(
  parameter int COLOR_W  = 8,
  parameter int AUX_W    = 2,
  localparam int DATA_W  = 3 * COLOR_W + 3,
  localparam int WORD_W  = DATA_W + AUX_W + 1,
  localparam int SW      = $clog2(WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           lane_sel,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [COLOR_W-1:0]   pix_red,
  input  logic [COLOR_W-1:0]   pix_green,
  input  logic [COLOR_W-1:0]   pix_blue,
  input  logic                 pix_hsync_n,
  input  logic                 pix_vsync_n,
  input  logic                 pix_de,
  input  logic [AUX_W-1:0]     pix_aux,
  output logic [MAX_LANES-1:0] ser_data,
  output logic                 ser_valid,
  output logic                 ser_first
);
  logic [WORD_W-1:0] packed_word;
  logic [WORD_W-1:0] held_word;
  lane_cnt_t         sel_cnt;
  lane_cnt_t         held_cnt;
  logic [SW-1:0]     sel_last;
  logic [SW-1:0]     cur_slot;
  logic              busy;

  pxser_word_pack #(.COLOR_W(COLOR_W), .AUX_W(AUX_W)) u_pack (
    .red(pix_red), .green(pix_green), .blue(pix_blue),
    .hsync_n(pix_hsync_n), .vsync_n(pix_vsync_n), .de(pix_de),
    .aux(pix_aux), .word(packed_word)
  );

  pxser_lane_decode #(.WORD_W(WORD_W)) u_dec (
    .lane_sel(lane_sel), .lane_cnt(sel_cnt), .last_slot(sel_last)
  );

  pxser_slot_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_valid), .in_ready(pix_ready),
    .word_in(packed_word), .cnt_in(sel_cnt), .last_in(sel_last),
    .busy(busy), .slot(cur_slot), .cnt_q(held_cnt), .word_q(held_word)
  );

  pxser_lane_mux #(.WORD_W(WORD_W)) u_mux (
    .busy(busy), .slot(cur_slot), .cnt(held_cnt), .word(held_word), .lanes(ser_data)
  );

  assign ser_valid = busy;
  assign ser_first = busy && (cur_slot == '0);

  AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (^{held_word[WORD_W-1], held_word[DATA_W-1:0]}) == 1'b1); // R2
  AST_FIRST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_first |=> !ser_first); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> (ser_data == '0 && !ser_first)); // R7
  AST_SPARE_LANE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (held_cnt < 2'd3) |-> !ser_data[2]); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> pix_ready); // R5
endmodule

// File: tb/sim_pix_lane_serializer.sv
`timescale 1ns/1ps
module sim_pix_lane_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lane_sel = 2'd1;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_red = '0, pix_green = '0, pix_blue = '0;
  logic       pix_hsync_n = 1'b1, pix_vsync_n = 1'b1, pix_de = 1'b0;
  logic [1:0] pix_aux = '0;
  logic [2:0] ser_data;
  logic       ser_valid, ser_first;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pix_lane_serializer u0 (
    .clk(clk), .rst_n(rst_n), .lane_sel(lane_sel),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .pix_hsync_n(pix_hsync_n), .pix_vsync_n(pix_vsync_n), .pix_de(pix_de),
    .pix_aux(pix_aux), .ser_data(ser_data), .ser_valid(ser_valid), .ser_first(ser_first)
  );

  // reference model state
  bit        m_busy = 0;
  int        m_slot = 0;
  int        m_n = 1;
  int        m_slots = 30;
  bit [29:0] m_word = '0;
  bit [29:0] rec = '0;
  int        obs_len = 0;
  int        obs_n = 1;

  function automatic int lanes_for(input logic [1:0] s);
    if (s == 2'd2) return 2;
    if (s == 2'd3) return 3;
    return 1;
  endfunction

  function automatic bit [29:0] make_word();
    bit [26:0] d;
    d = {pix_de, pix_vsync_n, pix_hsync_n, pix_blue, pix_green, pix_red};
    return {~(^d), pix_aux, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rdy;
    rdy = !m_busy || (m_slot == m_slots - 1);
    if (pix_valid && rdy) begin
      m_word  = make_word();
      m_n     = lanes_for(lane_sel);
      m_slots = 30 / m_n;
      m_slot  = 0;
      m_busy  = 1;
    end else if (m_busy) begin
      if (m_slot == m_slots - 1) m_busy = 0;
      else m_slot++;
    end
  endtask

  task automatic compare();
    bit exp_rdy;
    bit exp_bit;
    exp_rdy = !m_busy || (m_slot == m_slots - 1);
    check(pix_ready == exp_rdy, "R5 ready", pix_ready, exp_rdy);
    check(ser_valid == m_busy, "R7 valid", ser_valid, m_busy);
    check(ser_first == (m_busy && m_slot == 0), "R6 first", ser_first, (m_busy && m_slot == 0));
    for (int i = 0; i < 3; i++) begin
      if (!m_busy) begin
        check(ser_data[i] == 1'b0, "R7 idle lane", ser_data[i], 0);
      end else if (i >= m_n) begin
        check(ser_data[i] == 1'b0, "R8 spare lane", ser_data[i], 0);
      end else begin
        exp_bit = m_word[m_slot * m_n + i];
        if (lanes_for(lane_sel) != m_n)
          check(ser_data[i] == exp_bit, "R9 lane under changed select", ser_data[i], exp_bit);
        else
          check(ser_data[i] == exp_bit, "R4 lane bit", ser_data[i], exp_bit);
      end
    end
    // R3: slot count per word, observed independently from the outputs
    if (ser_first) begin
      if (obs_len > 0) check(obs_len == 30 / obs_n, "R3 slots per word", obs_len, 30 / obs_n);
      obs_len = 0;
      obs_n = m_n;
    end
    if (ser_valid) obs_len++;
    if (m_busy) begin
      for (int i = 0; i < m_n; i++) rec[m_slot * m_n + i] = ser_data[i];
      if (m_slot == m_slots - 1) begin
        check(^{rec[29], rec[26:0]} == 1'b1, "R2 odd parity", ^{rec[29], rec[26:0]}, 1);
        check(rec == m_word, "R1 word layout", rec, m_word);
      end
    end
  endtask

  task automatic drive(input int mode, input int vpct);
    pix_valid   = ($urandom_range(99) < vpct);
    pix_red     = 8'($urandom);
    pix_green   = 8'($urandom);
    pix_blue    = 8'($urandom);
    pix_hsync_n = 1'($urandom);
    pix_vsync_n = 1'($urandom);
    pix_de      = 1'($urandom);
    pix_aux     = 2'($urandom);
    if (mode == 4) lane_sel = 2'($urandom);
  endtask

  task automatic run_phase(input logic [1:0] sel, input int mode, input int vpct, input int cycles);
    lane_sel = sel;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      model_step();
      compare();
      drive(mode, vpct);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pix_ready == 1'b1, "R10 reset ready", pix_ready, 1);
    check(ser_valid == 1'b0, "R10 reset valid", ser_valid, 0);
    check(ser_first == 1'b0, "R10 reset first", ser_first, 0);
    check(ser_data == 3'b000, "R10 reset lanes", ser_data, 0);
    run_phase(2'd1, 0, 100, 200);
    run_phase(2'd2, 0, 100, 150);
    run_phase(2'd3, 0, 100, 120);
    run_phase(2'd3, 0, 50, 200);
    run_phase(2'd0, 0, 100, 100);
    run_phase(2'd2, 4, 70, 500);
    run_phase(2'd1, 0, 0, 40);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule